// File: doc/BRIEF.md
# Sprint-Level Node Activation Controller

This block decides which nodes of a 4x4 on-chip mesh are powered for a given sprint level. A controller above it supplies a requested number of active cores together with a one-cycle load strobe. The block turns that number into an active-node mask, a power-gate enable for every node left out of the set, and a pair of horizontal link bits per router that the route computation uses to avoid dead neighbours.

Nodes join the active set in a fixed order that the hardware works out from node coordinates relative to the master node (node 0, top-left, beside the memory controller). A node's place in the order is its squared distance from the master, with equal distances resolved by the lower node index first. The order is therefore 0,1,4,5,2,8,6,9,10,3,12,7,13,11,14,15, and every prefix of it is a convex patch of the mesh. Node i sits at column i mod 4 and row i div 4.

Top module: `sprint_node_ctrl`

## Requirements
- R1: After reset the active mask is 16'h0001: only the master node 0 is on.
- R2: For a clamped level k, the active mask holds exactly the first k nodes of the order 0,1,4,5,2,8,6,9,10,3,12,7,13,11,14,15 (bit i of the mask is node i).
- R3: Level 3 activates nodes {0,1,4} (mask 16'h0013); level 4 adds node 5 and not node 2 (mask 16'h0033).
- R4: Nodes at equal distance join in ascending index: level 5 adds node 2 without node 8 (16'h0037), level 6 adds node 8 (16'h0137).
- R5: A requested level of 0 is treated as 1 and a level above 16 is treated as 16 (mask 16'hFFFF).
- R6: The mask changes on the first clock edge on which the load strobe is sampled high and is visible after it; without a strobe it holds, whatever the level input does.
- R7: The gate-enable output is the bitwise complement of the active mask.
- R8: The east link bit of node i is 1 only when node i and node i+1 are both active and in the same row (column of i below 3).
- R9: The west link bit of node i is 1 only when node i and node i-1 are both active and in the same row (column of i above 0).
- R10: The master node is active at every sprint level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Strobe: capture level_i this cycle |
| level_i | input | 5 | Requested number of active nodes |
| active_mask_o | output | 16 | One bit per node, 1 = powered |
| gate_en_o | output | 16 | One bit per node, 1 = power-gated |
| conn_east_o | output | 16 | Per-router east neighbour connected |
| conn_west_o | output | 16 | Per-router west neighbour connected |

## Verification
The bench aims at the distance ties, where a design ordering by row or by Manhattan distance would pick node 2 before node 5 or node 8 before node 2, and at the clamps, where a missing saturation would leave the mesh dark at level 0 or wrap to a small set above 16. Row edges are checked so that a link-bit derivation that ignores the column would connect node 3 to node 4 across the wrap. Level changes without a strobe are driven between loads to catch a mask that follows the input directly instead of the captured value.

// File: rtl/sprint_pkg.sv
package sprint_pkg;

  function automatic int unsigned node_col(input int unsigned idx, input int unsigned width);
    return idx % width;
  endfunction

  function automatic int unsigned node_row(input int unsigned idx, input int unsigned width);
    return idx / width;
  endfunction

  // Squared Euclidean distance between two node indices: same order as the root.
  function automatic int unsigned dist_sq(input int unsigned a, input int unsigned b,
                                          input int unsigned width);
    int dx;
    int dy;
    dx = int'(node_col(a, width)) - int'(node_col(b, width));
    dy = int'(node_row(a, width)) - int'(node_row(b, width));
    return int'(dx * dx + dy * dy);
  endfunction

  // Saturate a request into the legal range 1..nodes.
  function automatic int unsigned sat_level(input int unsigned req, input int unsigned nodes);
    if (req == 0) return 1;
    if (req > nodes) return nodes;
    return req;
  endfunction

endpackage

// File: rtl/sprint_level_reg.sv
module sprint_level_reg #(
  parameter int unsigned NODES = 16,
  parameter int unsigned CNT_W = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] level_i,
  output logic [CNT_W-1:0] level_q
);
  localparam logic [CNT_W-1:0] LVL_MIN = CNT_W'(1);
  localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(NODES);

  logic [CNT_W-1:0] sat_lvl;
  logic [CNT_W-1:0] level_d;

  always_comb begin
    if (level_i == '0) begin
      sat_lvl = LVL_MIN;
    end else if (level_i > LVL_MAX) begin
      sat_lvl = LVL_MAX;
    end else begin
      sat_lvl = level_i;
    end
    level_d = load_i ? sat_lvl : level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LVL_MIN;
    end else begin
      level_q <= level_d;
    end
  end
endmodule

// File: rtl/sprint_node_rank.sv
module sprint_node_rank #(
  parameter int unsigned NODES      = 16,
  parameter int unsigned MESH_W     = 4,
  parameter int unsigned MASTER_IDX = 0,
  parameter int unsigned NODE_IDX   = 0,
  parameter int unsigned RANK_W     = $clog2(NODES)
) (
  output logic [RANK_W-1:0] rank_o
);
  import sprint_pkg::*;

  localparam int unsigned MY_D = dist_sq(NODE_IDX, MASTER_IDX, MESH_W);

  // One bit per other node: that node precedes this one in the activation order.
  logic [NODES-1:0] ahead;

  for (genvar j = 0; j < NODES; j++) begin : g_cmp
    localparam int unsigned OTHER_D = dist_sq(j, MASTER_IDX, MESH_W);
    if (j == NODE_IDX) begin : g_self
      assign ahead[j] = 1'b0;
    end else begin : g_other
      logic closer;
      logic tie_first;
      assign closer    = (OTHER_D < MY_D);
      assign tie_first = (OTHER_D == MY_D) && (j < NODE_IDX);
      assign ahead[j]  = closer | tie_first;
    end
  end

  always_comb begin
    rank_o = '0;
    for (int k = 0; k < NODES; k++) begin
      rank_o = rank_o + RANK_W'(ahead[k]);
    end
  end
endmodule

// File: rtl/sprint_link_derive.sv
module sprint_link_derive #(
  parameter int unsigned MESH_W = 4,
  parameter int unsigned NODES  = 16
) (
  input  logic [NODES-1:0] mask_i,
  output logic [NODES-1:0] east_o,
  output logic [NODES-1:0] west_o
);
  for (genvar i = 0; i < NODES; i++) begin : g_node
    if ((i % MESH_W) != (MESH_W - 1)) begin : g_has_east
      assign east_o[i] = mask_i[i] & mask_i[i+1];
    end else begin : g_edge_east
      assign east_o[i] = 1'b0;
    end
    if ((i % MESH_W) != 0) begin : g_has_west
      assign west_o[i] = mask_i[i] & mask_i[i-1];
    end else begin : g_edge_west
      assign west_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sprint_node_ctrl.sv
module sprint_node_ctrl #(
  parameter int unsigned MESH_W     = 4,
  parameter int unsigned MESH_H     = 4,
  parameter int unsigned MASTER_IDX = 0,
  parameter int unsigned NODES      = MESH_W * MESH_H,
  parameter int unsigned CNT_W      = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] level_i,
  output logic [NODES-1:0] active_mask_o,
  output logic [NODES-1:0] gate_en_o,
  output logic [NODES-1:0] conn_east_o,
  output logic [NODES-1:0] conn_west_o
);
  localparam int unsigned RANK_W = $clog2(NODES);

  logic [CNT_W-1:0]  level_q;
  logic [RANK_W-1:0] rank_w [NODES];
  logic [NODES-1:0]  mask_w;

  sprint_level_reg #(.NODES(NODES), .CNT_W(CNT_W)) level_reg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .level_i (level_i),
    .level_q (level_q)
  );

  for (genvar i = 0; i < NODES; i++) begin : g_rank
    sprint_node_rank #(
      .NODES      (NODES),
      .MESH_W     (MESH_W),
      .MASTER_IDX (MASTER_IDX),
      .NODE_IDX   (i),
      .RANK_W     (RANK_W)
    ) rank_i (
      .rank_o (rank_w[i])
    );
    // A node is on when fewer nodes precede it than the captured level.
    assign mask_w[i] = (CNT_W'(rank_w[i]) < level_q);
  end

  sprint_link_derive #(.MESH_W(MESH_W), .NODES(NODES)) link_i (
    .mask_i (mask_w),
    .east_o (conn_east_o),
    .west_o (conn_west_o)
  );

  assign active_mask_o = mask_w;
  assign gate_en_o     = ~mask_w;
endmodule

// File: rtl/sprint_node_ctrl_chk.sv
module sprint_node_ctrl_chk #(
  parameter int unsigned MESH_W     = 4,
  parameter int unsigned MASTER_IDX = 0,
  parameter int unsigned NODES      = 16,
  parameter int unsigned CNT_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [CNT_W-1:0] level_i,
  input logic [NODES-1:0] active_mask_o,
  input logic [NODES-1:0] gate_en_o,
  input logic [NODES-1:0] conn_east_o,
  input logic [NODES-1:0] conn_west_o
);
  import sprint_pkg::*;

  assert_master_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask_o[MASTER_IDX]);

  assert_load_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_i) |-> ($countones(active_mask_o) == int'(sat_level($past(level_i), NODES))));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_i) |-> $stable(active_mask_o));

  // Growing the level never drops a node that was already on (prefix order).
  assert_nested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_i) && ($countones(active_mask_o) >= $countones($past(active_mask_o))))
    |-> (($past(active_mask_o) & ~active_mask_o) == '0));

  assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_o & active_mask_o) == '0);

  assert_west_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_west_o & ~active_mask_o) == '0);

  for (genvar i = 0; i < NODES; i++) begin : g_pair
    if ((i % MESH_W) != (MESH_W - 1)) begin : g_chk
      assert_link_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conn_east_o[i] == conn_west_o[i+1]);
    end
  end
endmodule

bind sprint_node_ctrl sprint_node_ctrl_chk #(
  .MESH_W     (MESH_W),
  .MASTER_IDX (MASTER_IDX),
  .NODES      (NODES),
  .CNT_W      (CNT_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .load_i        (load_i),
  .level_i       (level_i),
  .active_mask_o (active_mask_o),
  .gate_en_o     (gate_en_o),
  .conn_east_o   (conn_east_o),
  .conn_west_o   (conn_west_o)
);

// File: tb/sprint_node_ctrl_tb.sv
module sprint_node_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [4:0]  level_i;
  logic [15:0] active_mask_o;
  logic [15:0] gate_en_o;
  logic [15:0] conn_east_o;
  logic [15:0] conn_west_o;

  int n_checks;
  int n_fails;
  int cycles;
  bit done;

  localparam int ORDER [16] = '{0, 1, 4, 5, 2, 8, 6, 9, 10, 3, 12, 7, 13, 11, 14, 15};

  sprint_node_ctrl dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load_i),
    .level_i       (level_i),
    .active_mask_o (active_mask_o),
    .gate_en_o     (gate_en_o),
    .conn_east_o   (conn_east_o),
    .conn_west_o   (conn_west_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int clamp_lvl(input int req);
    if (req < 1) return 1;
    if (req > 16) return 16;
    return req;
  endfunction

  function automatic logic [15:0] exp_mask(input int req);
    logic [15:0] m;
    m = '0;
    for (int k = 0; k < clamp_lvl(req); k++) m[ORDER[k]] = 1'b1;
    return m;
  endfunction

  function automatic logic [15:0] exp_east(input logic [15:0] m);
    logic [15:0] e;
    e = '0;
    for (int i = 0; i < 16; i++)
      if ((i % 4) != 3) e[i] = m[i] & m[i+1];
    return e;
  endfunction

  function automatic logic [15:0] exp_west(input logic [15:0] m);
    logic [15:0] w;
    w = '0;
    for (int i = 0; i < 16; i++)
      if ((i % 4) != 0) w[i] = m[i] & m[i-1];
    return w;
  endfunction

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Full output check against a mask expected from the requirements.
  task automatic check_all(input string req, input logic [15:0] m);
    check16(req, active_mask_o, m);
    check16("R7", gate_en_o, ~m);
    check16("R8", conn_east_o, exp_east(m));
    check16("R9", conn_west_o, exp_west(m));
    check16("R10", {15'd0, active_mask_o[0]}, 16'h0001);
  endtask

  task automatic load_level(input int lvl);
    @(negedge clk);
    load_i  = 1'b1;
    level_i = 5'(lvl);
    @(negedge clk);
    load_i  = 1'b0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
        report();
      end
    end
  end

  initial begin
    logic [15:0] held;
    int lvl;
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    load_i   = 1'b0;
    level_i  = 5'd9;
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_all("R1", 16'h0001);

    // R3: three- and four-node sprints
    load_level(3);
    check_all("R3", 16'h0013);
    load_level(4);
    check_all("R3", 16'h0033);

    // R4: equal-distance tie order
    load_level(5);
    check_all("R4", 16'h0037);
    load_level(6);
    check_all("R4", 16'h0137);

    // R5: clamps
    load_level(0);
    check_all("R5", 16'h0001);
    load_level(31);
    check_all("R5", 16'hFFFF);
    load_level(17);
    check_all("R5", 16'hFFFF);

    // R2: every level in turn
    for (int k = 1; k <= 16; k++) begin
      load_level(k);
      check_all("R2", exp_mask(k));
    end

    // R6: level changes without a strobe have no effect
    load_level(7);
    held = active_mask_o;
    @(negedge clk);
    level_i = 5'd2;
    repeat (3) @(negedge clk);
    check16("R6", active_mask_o, held);
    level_i = 5'd16;
    repeat (2) @(negedge clk);
    check16("R6", active_mask_o, exp_mask(7));

    // Random levels, with occasional idle gaps that must hold the mask (R6)
    for (int n = 0; n < 200; n++) begin
      lvl = int'($urandom_range(0, 31));
      load_level(lvl);
      check_all("R2", exp_mask(lvl));
      if ($urandom_range(0, 3) == 0) begin
        level_i = 5'($urandom_range(0, 31));
        @(negedge clk);
        check16("R6", active_mask_o, exp_mask(lvl));
      end
    end

    report();
  end
endmodule